// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. A producer offers a word of up to nine bits with a valid/ready handshake. When a word is accepted the block takes a snapshot of three configuration fields: a character size, a parity mode and a stop-bit count. It then sends a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. After that it returns to an idle-high line and raises ready again.

Bit timing comes from outside the block as a single-cycle enable pulse, one per bit period. Each pulse ends the bit that is currently on the line. The block does not divide clocks or buffer data. It holds one frame in flight and accepts the next word only after the last stop bit has ended.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, `txLine` is 1 and `inReady` is 1.
- R2: A word is accepted on a rising clock edge where `inValid` and `inReady` are both 1. `inReady` is 0 from the next cycle until the rate pulse that ends the final stop bit. It is 1 again in the cycle after that pulse.
- R3: In the cycle after acceptance `txLine` carries the start bit (0). Every bit stays on the line until a cycle with `bitTick` = 1, and the next bit appears in the following cycle.
- R4: Data bits go out least significant first. The size code sets the count: 000 gives 5 bits, 001 gives 6, 010 gives 7, 011 gives 8 and 111 gives 9.
- R5: The size codes 100, 101 and 110 each send 8 data bits.
- R6: Parity code 10 appends an even-parity bit and code 11 appends an odd-parity bit. The bit follows the last data bit and is computed over the transmitted data bits only.
- R7: Parity codes 00 and 01 send no parity bit, so the stop bit follows the last data bit directly.
- R8: Stop code 0 sends one stop bit and stop code 1 sends two stop bits. Stop bits are 1.
- R9: All three configuration fields are captured at acceptance. Changing them during a frame does not alter that frame.
- R10: Data bits above the selected size are not sent and do not affect the parity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| inData | input | 9 | Character to send, bit 0 goes out first |
| inValid | input | 1 | Producer offers `inData` |
| inReady | output | 1 | Block can accept a word this cycle |
| bitTick | input | 1 | One-cycle pulse that ends the current bit period |
| parityMode | input | 2 | 00/01 none, 10 even, 11 odd |
| stopMode | input | 1 | 0 one stop bit, 1 two stop bits |
| sizeCode | input | 3 | 000..011 give 5..8 bits, 111 gives 9 bits, others give 8 bits |
| txLine | output | 1 | Serial output, idles high |

## Verification
The hardest case to reach from the ports is a configuration that changes while a frame is on the line. A wrong design that reads the live fields would then produce a frame that mixes two formats. The driver changes every configuration field, and the data word, in the cycle right after each acceptance, so every frame in the run tests R9. Back-to-back frames are offered in the first cycle that ready returns. This exposes a stop bit that is missing or doubled, because the next start bit would then land in the wrong rate period.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

  // Selects what the datapath puts on the line.
  typedef enum logic [1:0] {
    SEL_MARK   = 2'd0,
    SEL_START  = 2'd1,
    SEL_DATA   = 2'd2,
    SEL_PARITY = 2'd3
  } lineSel_t;

  typedef struct packed {
    logic     load;
    logic     shift;
    lineSel_t sel;
  } strobe_t;

  // Character size decode; the reserved codes fall back to eight bits.
  function automatic logic [3:0] sizeToBits(input logic [2:0] code);
    case (code)
      3'b000:  return 4'd5;
      3'b001:  return 4'd6;
      3'b010:  return 4'd7;
      3'b111:  return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/uftx_ctrl.sv
module uftx_ctrl
  import uftx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       bitTick,
  input  logic       parEnable,
  input  logic       stopMode,
  input  logic [2:0] sizeCode,
  output logic       inReady,
  output strobe_t    strb
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } state_t;

  state_t     state, stateNext;
  logic [3:0] bitsLeft, bitsLeftNext;
  logic       parOn, twoStop;
  logic       accept;

  assign inReady = (state == ST_IDLE);
  assign accept  = inValid && inReady;

  always_comb begin
    stateNext    = state;
    bitsLeftNext = bitsLeft;
    strb.load    = accept;
    strb.shift   = 1'b0;
    strb.sel     = SEL_MARK;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          stateNext    = ST_START;
          bitsLeftNext = sizeToBits(sizeCode);
        end
      end
      ST_START: begin
        strb.sel = SEL_START;
        if (bitTick) stateNext = ST_DATA;
      end
      ST_DATA: begin
        strb.sel = SEL_DATA;
        if (bitTick) begin
          strb.shift = 1'b1;
          if (bitsLeft == 4'd1) stateNext = parOn ? ST_PAR : ST_STOP1;
          else                  bitsLeftNext = bitsLeft - 4'd1;
        end
      end
      ST_PAR: begin
        strb.sel = SEL_PARITY;
        if (bitTick) stateNext = ST_STOP1;
      end
      ST_STOP1: begin
        if (bitTick) stateNext = twoStop ? ST_STOP2 : ST_IDLE;
      end
      ST_STOP2: begin
        if (bitTick) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitsLeft <= '0;
      parOn    <= 1'b0;
      twoStop  <= 1'b0;
    end else begin
      state    <= stateNext;
      bitsLeft <= bitsLeftNext;
      if (accept) begin
        parOn   <= parEnable;
        twoStop <= stopMode;
      end
    end
  end

endmodule

// File: rtl/uftx_datapath.sv
module uftx_datapath
  import uftx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] inData,
  input  logic              parOdd,
  input  logic [2:0]        sizeCode,
  output logic              txLine
);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] sizeMask;
  logic [DATA_W-1:0] masked;
  logic [3:0]        nBits;
  logic              parBit;

  assign nBits = sizeToBits(sizeCode);

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign sizeMask[i] = (4'(i) < nBits);
  end

  assign masked = inData & sizeMask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (strb.load) begin
      shiftReg <= masked;
      parBit   <= (^masked) ^ parOdd;
    end else if (strb.shift) begin
      shiftReg <= shiftReg >> 1;
    end
  end

  always_comb begin
    case (strb.sel)
      SEL_START:  txLine = 1'b0;
      SEL_DATA:   txLine = shiftReg[0];
      SEL_PARITY: txLine = parBit;
      default:    txLine = 1'b1;
    endcase
  end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uftx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              bitTick,
  input  logic [1:0]        parityMode,
  input  logic              stopMode,
  input  logic [2:0]        sizeCode,
  output logic              txLine
);

  strobe_t strb;

  uftx_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .inValid   (inValid),
    .bitTick   (bitTick),
    .parEnable (parityMode[1]),
    .stopMode  (stopMode),
    .sizeCode  (sizeCode),
    .inReady   (inReady),
    .strb      (strb)
  );

  uftx_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .inData   (inData),
    .parOdd   (parityMode[0]),
    .sizeCode (sizeCode),
    .txLine   (txLine)
  );

endmodule

// File: rtl/uftx_checker.sv
module uftx_checker (
  input logic clk,
  input logic rst_n,
  input logic inValid,
  input logic inReady,
  input logic bitTick,
  input logic txLine
);

  // R1: an idle block holds the line high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    inReady |-> txLine);

  // R2: acceptance drops ready in the next cycle
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> !inReady);

  // R2: ready comes back only after a rate pulse
  a_r2_ready_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inReady) |-> $past(bitTick));

  // R3: the first busy cycle carries the start bit
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inReady) |-> !txLine);

  // R3: without a rate pulse the line and the busy state hold
  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!inReady && !bitTick) |=> ($stable(txLine) && !inReady));

endmodule

bind uart_frame_tx uftx_checker chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .inValid (inValid),
  .inReady (inReady),
  .bitTick (bitTick),
  .txLine  (txLine)
);

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    logic [15:0] bits;
    int          len;
    string       tag;
  } frame_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic       bitTick = 1'b0;
  logic [1:0] parityMode = '0;
  logic       stopMode = 1'b0;
  logic [2:0] sizeCode = '0;
  logic       txLine;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  frame_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_frame_tx dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .inData     (inData),
    .inValid    (inValid),
    .inReady    (inReady),
    .bitTick    (bitTick),
    .parityMode (parityMode),
    .stopMode   (stopMode),
    .sizeCode   (sizeCode),
    .txLine     (txLine)
  );

  // Free-running bit-rate pulse, changed at the falling edge.
  int tickCnt = 0;
  always @(negedge clk) begin
    tickCnt = (tickCnt == TICK_DIV-1) ? 0 : tickCnt + 1;
    bitTick = (tickCnt == 0);
  end

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int sizeOf(input logic [2:0] c);
    case (c)
      3'b000: return 5;
      3'b001: return 6;
      3'b010: return 7;
      3'b111: return 9;
      default: return 8;
    endcase
  endfunction

  // Driver: builds the expected frame, then performs the handshake.
  task automatic sendFrame(input logic [8:0] d, input logic [1:0] pm, input logic sm,
                           input logic [2:0] sz, input string tag);
    frame_t e;
    int n, k;
    logic p;
    n = sizeOf(sz);
    e.bits = '1;
    k = 0;
    p = 1'b0;
    e.bits[k] = 1'b0; k++;
    for (int i = 0; i < n; i++) begin
      e.bits[k] = d[i]; p ^= d[i]; k++;
    end
    if (pm == 2'b10) begin e.bits[k] = p;  k++; end
    if (pm == 2'b11) begin e.bits[k] = ~p; k++; end
    e.bits[k] = 1'b1; k++;
    if (sm) begin e.bits[k] = 1'b1; k++; end
    e.len = k;
    e.tag = tag;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    expQ.push_back(e);
    inData = d; parityMode = pm; stopMode = sm; sizeCode = sz; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    // R9: scramble everything once the word is taken
    inData = ~d; parityMode = ~pm; stopMode = ~sm; sizeCode = sz ^ 3'b101;
    check(!inReady, "R2 busy after accept", 16'(inReady), 16'h0);
    check(!txLine, "R3 start bit", 16'(txLine), 16'h0);
  endtask

  // Monitor: collects one bit per rate pulse and compares whole frames.
  bit inFrame = 0;
  bit readyPending = 0;
  int gotN = 0;
  logic [15:0] got;
  frame_t cur;
  always @(negedge clk) begin
    if (rst_n) begin
      if (readyPending) begin
        check(inReady, "R2 ready after last stop", 16'(inReady), 16'h1);
        readyPending = 0;
      end
      if (bitTick) begin
        if (!inFrame) begin
          if (!txLine) begin
            inFrame = 1;
            got = '1;
            got[0] = 1'b0;
            gotN = 1;
            if (expQ.size() == 0) begin
              check(0, "R1 unexpected start bit", 16'h0, 16'h1);
              inFrame = 0;
            end else begin
              cur = expQ.pop_front();
            end
          end
        end else begin
          got[gotN] = txLine;
          gotN++;
        end
        if (inFrame && gotN == cur.len) begin
          check(got == cur.bits, cur.tag, got, cur.bits);
          inFrame = 0;
          readyPending = 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(inReady == 1'b1, "R1 ready after reset", 16'(inReady), 16'h1);
    check(txLine == 1'b1, "R1 line after reset", 16'(txLine), 16'h1);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(txLine == 1'b1, "R1 idle line", 16'(txLine), 16'h1);

    sendFrame(9'h0A5, 2'b00, 1'b0, 3'b011, "R4 8 bits no parity");
    sendFrame(9'h015, 2'b00, 1'b0, 3'b000, "R4 5 bits");
    sendFrame(9'h02C, 2'b10, 1'b0, 3'b001, "R6 6 bits even");
    sendFrame(9'h05B, 2'b11, 1'b0, 3'b010, "R6 7 bits odd");
    sendFrame(9'h1C3, 2'b10, 1'b1, 3'b111, "R4 9 bits even two stops");
    sendFrame(9'h0F0, 2'b11, 1'b1, 3'b011, "R8 two stops odd");
    sendFrame(9'h1FF, 2'b00, 1'b0, 3'b100, "R5 size code 100");
    sendFrame(9'h13C, 2'b10, 1'b0, 3'b101, "R5 size code 101");
    sendFrame(9'h181, 2'b11, 1'b1, 3'b110, "R5 size code 110");
    sendFrame(9'h0D2, 2'b01, 1'b0, 3'b011, "R7 reserved parity 01");
    sendFrame(9'h1E0, 2'b10, 1'b0, 3'b000, "R10 high bits ignored");
    sendFrame(9'h1E1, 2'b11, 1'b1, 3'b000, "R10 high bits odd parity");
    sendFrame(9'h000, 2'b11, 1'b0, 3'b011, "R6 zero data odd");
    sendFrame(9'h1FF, 2'b10, 1'b1, 3'b111, "R9 config held");
    sendFrame(9'h055, 2'b00, 1'b1, 3'b010, "R8 two stops no parity");

    while (expQ.size() != 0 || inFrame) @(negedge clk);
    repeat (TICK_DIV * 6) @(negedge clk);
    check(txLine == 1'b1 && inReady == 1'b1, "R1 idle after traffic",
          16'({txLine, inReady}), 16'h3);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule